// File: doc/BRIEF.md
# Block Transfer Sequencer

This block moves a set of registers to or from consecutive memory words, one word per clock. A command carries a base address, a 16-bit register mask, a direction (load or store), a two-bit walk mode and a writeback flag. The sequencer walks the mask from the lowest register number up and issues one memory access per set bit. The register with the lowest number always lands at the lowest address.

The walk mode decides where the run of words sits relative to the base. It can sit above the base or below it, and it can start at the base or one word away from it. For a store, each cycle the register file is read and memory is written. For a load, each cycle memory is read and the register file is written. Memory and register-file reads are both combinational, and both writes are taken at the clock edge. When the last word is done, the block pulses `done` and presents the new base value. That value is the end of the run when writeback is requested, and the original base otherwise.

Commands arrive on a valid/ready handshake. `cmd_ready` is high exactly when no transfer is running, and that includes the cycle in which `done` pulses. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. The sender must keep `cmd_valid` and every command field stable until that edge. Back-pressure lasts for the whole transfer, which is one cycle per listed register. Descending stack use is a store in mode 3 with writeback (push), followed by a load in mode 0 with writeback (pop).

Top module: `blk_xfer_seq`

## Requirements
- R1: `cmd_ready` is 1 when idle and 0 while a transfer runs. While busy, a held `cmd_valid` is not taken, and no memory access happens while `cmd_ready` is 1.
- R2: Accesses go one per cycle with no gaps. Register numbers rise strictly and each address is 4 above the previous one.
- R3: Mode 0 (upward, step after) starts at the base. Mode 1 (upward, step before) starts at base+4.
- R4: With n = number of set mask bits, mode 2 (downward, step after) starts at base-4n+4. Mode 3 (downward, step before) starts at base-4n.
- R5: A store (`cmd_load`=0) asserts `mem_we` only. It puts `rf_rdata` of the register named on `rf_raddr` onto `mem_wdata`.
- R6: A load (`cmd_load`=1) asserts `mem_re` and `rf_we` together. It writes `mem_rdata` into the register named on `rf_waddr`.
- R7: With `cmd_wback`=1, `base_out` becomes base+4n in modes 0 and 1 and base-4n in modes 2 and 3. With `cmd_wback`=0 it is the base.
- R8: An empty mask makes no access and pulses `done` in the cycle after acceptance, with `base_out` equal to the base.
- R9: `done` is a one-cycle pulse in the cycle right after the last access, and `base_out` is valid with it.
- R10: A mode-3 writeback store followed by a mode-0 writeback load with the same mask restores the registers and the original base.
- R11: A command waiting during the `done` cycle is taken in that cycle. Its first access follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this edge if valid |
| cmd_base | input | ADDR_W | Base address |
| cmd_list | input | NREG | Register mask |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_mode | input | 2 | Walk mode 0..3 |
| cmd_wback | input | 1 | Update base at end |
| mem_addr | output | ADDR_W | Word byte address |
| mem_wdata | output | DATA_W | Store data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | DATA_W | Memory read data (combinational) |
| rf_raddr | output | IDX_W | Register read index |
| rf_rdata | input | DATA_W | Register read data (combinational) |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | IDX_W | Register write index |
| rf_wdata | output | DATA_W | Register write data |
| done | output | 1 | Transfer finished pulse |
| base_out | output | ADDR_W | Resulting base value |

## Verification
The `done` pulse of one transfer and the acceptance of the next command can happen in the same cycle. The bench sets this up by queuing a load right behind a two-word store, so `cmd_valid` is held high through the store. It checks three things: `done` and `cmd_ready` are both high in that cycle, the store's base is reported correctly, and the load's first access appears in the very next cycle at the expected address.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  // Bit 1 selects a downward run, bit 0 selects stepping before the first word.
  typedef enum logic [1:0] {
    WALK_UP_AFTER  = 2'b00,
    WALK_UP_BEFORE = 2'b01,
    WALK_DN_AFTER  = 2'b10,
    WALK_DN_BEFORE = 2'b11
  } walk_mode_e;
endpackage

// File: rtl/blk_xfer_span.sv
module blk_xfer_span #(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [NREG-1:0]   list,
  input  logic [1:0]        mode,
  input  logic              wback,
  output logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] next_base
);
  import blk_xfer_pkg::*;
  localparam int CNT_W = $clog2(NREG + 1);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] end_addr;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CNT_W'(list[i]);
  end

  assign span = ADDR_W'(cnt) * STEP_A;

  always_comb begin
    unique case (walk_mode_e'(mode))
      WALK_UP_AFTER:  start_addr = base;
      WALK_UP_BEFORE: start_addr = base + STEP_A;
      WALK_DN_AFTER:  start_addr = base - span + STEP_A;
      default:        start_addr = base - span;
    endcase
  end

  assign end_addr  = mode[1] ? (base - span) : (base + span);
  assign next_base = wback ? end_addr : base;
endmodule

// File: rtl/blk_xfer_pick.sv
module blk_xfer_pick #(
  parameter int NREG  = 16,
  parameter int IDX_W = 4
) (
  input  logic [NREG-1:0]  list,
  output logic [NREG-1:0]  onehot,
  output logic [IDX_W-1:0] idx
);
  logic [NREG-1:0] lower_set;

  assign lower_set[0] = 1'b0;
  for (genvar g = 1; g < NREG; g++) begin : g_chain
    assign lower_set[g] = lower_set[g-1] | list[g-1];
  end
  assign onehot = list & ~lower_set;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (onehot[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  parameter int STEP   = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [NREG-1:0]   cmd_list,
  input  logic              cmd_load,
  input  logic [1:0]        cmd_mode,
  input  logic              cmd_wback,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              done,
  output logic [ADDR_W-1:0] base_out
);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

  logic              busy_q, load_q, done_q;
  logic [ADDR_W-1:0] cur_q, fin_q, base_q;
  logic [NREG-1:0]   remain_q;
  logic [ADDR_W-1:0] start_addr, next_base;
  logic [NREG-1:0]   pick_oh;
  logic [IDX_W-1:0]  pick_idx;
  logic              accept, last_word;

  blk_xfer_span #(.ADDR_W(ADDR_W), .NREG(NREG), .STEP(STEP)) u_span (
    .base(cmd_base), .list(cmd_list), .mode(cmd_mode), .wback(cmd_wback),
    .start_addr(start_addr), .next_base(next_base)
  );

  blk_xfer_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .list(remain_q), .onehot(pick_oh), .idx(pick_idx)
  );

  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && cmd_ready;
  assign last_word = (remain_q & ~pick_oh) == '0;

  assign mem_addr  = cur_q;
  assign mem_we    = busy_q && !load_q;
  assign mem_re    = busy_q && load_q;
  assign mem_wdata = rf_rdata;
  assign rf_raddr  = pick_idx;
  assign rf_waddr  = pick_idx;
  assign rf_we     = busy_q && load_q;
  assign rf_wdata  = mem_rdata;
  assign done      = done_q;
  assign base_out  = base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      load_q   <= 1'b0;
      done_q   <= 1'b0;
      cur_q    <= '0;
      fin_q    <= '0;
      base_q   <= '0;
      remain_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        remain_q <= remain_q & ~pick_oh;
        cur_q    <= cur_q + STEP_A;
        if (last_word) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          base_q <= fin_q;
        end
      end else if (accept) begin
        if (cmd_list == '0) begin
          done_q <= 1'b1;
          base_q <= cmd_base;
        end else begin
          busy_q   <= 1'b1;
          load_q   <= cmd_load;
          cur_q    <= start_addr;
          remain_q <= cmd_list;
          fin_q    <= next_base;
        end
      end
    end
  end
endmodule

// File: rtl/blk_xfer_chk.sv
module blk_xfer_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic [IDX_W-1:0]  rf_raddr,
  input logic              rf_we,
  input logic [IDX_W-1:0]  rf_waddr,
  input logic              done
);
  logic             acc;
  logic [IDX_W-1:0] acc_idx;
  assign acc     = mem_we || mem_re;
  assign acc_idx = mem_re ? rf_waddr : rf_raddr;

  a_r1_no_access_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !acc);
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc && $past(acc) |-> mem_addr == $past(mem_addr) + ADDR_W'(4));
  a_r2_order_up: assert property (@(posedge clk) disable iff (!rst_n)
    acc && $past(acc) |-> acc_idx > $past(acc_idx));
  a_r5_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}));
  a_r6_rf_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mem_re);
  a_r9_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(acc) || $past(cmd_valid && cmd_ready));
endmodule

bind blk_xfer_seq blk_xfer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
  .rf_raddr(rf_raddr), .rf_we(rf_we), .rf_waddr(rf_waddr), .done(done)
);

// File: tb/blk_xfer_seq_tb_top.sv
module blk_xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_list = '0;
  logic        cmd_load = 1'b0;
  logic [1:0]  cmd_mode = '0;
  logic        cmd_wback = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata, base_out;
  logic        mem_we, mem_re, rf_we, done;
  logic [3:0]  rf_raddr, rf_waddr;

  logic [31:0] mem_m [256];
  logic [31:0] regs  [16];

  always #5 clk = ~clk;

  blk_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_list(cmd_list), .cmd_load(cmd_load),
    .cmd_mode(cmd_mode), .cmd_wback(cmd_wback), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .done(done), .base_out(base_out)
  );

  assign mem_rdata = mem_m[mem_addr[9:2]];
  assign rf_rdata  = regs[rf_raddr];

  always @(posedge clk) begin
    if (mem_we) mem_m[mem_addr[9:2]] <= mem_wdata;
    if (rf_we)  regs[rf_waddr] <= rf_wdata;
  end

  typedef struct {
    logic        ld;
    logic [31:0] addr;
    logic [3:0]  idx;
    logic [31:0] data;
    logic        last;
  } acc_t;

  acc_t        exp_q[$];
  logic [31:0] base_q[$];
  int  errors = 0, checks = 0;
  bit  finished = 0, expect_done = 0, b2b_watch = 0, want_acc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: builds the expected accesses from the requirements, then offers the command.
  task automatic issue(input logic [31:0] base, input logic [15:0] list,
                       input logic ld, input logic [1:0] mode, input logic wb);
    int n = 0, k = 0;
    logic [31:0] a, fin;
    for (int i = 0; i < 16; i++) if (list[i]) n++;
    case (mode)
      2'd0: a = base;
      2'd1: a = base + 4;
      2'd2: a = base - 32'(4 * n) + 4;
      default: a = base - 32'(4 * n);
    endcase
    fin = mode[1] ? base - 32'(4 * n) : base + 32'(4 * n);
    for (int i = 0; i < 16; i++) begin
      if (list[i]) begin
        acc_t e;
        e.ld = ld; e.addr = a; e.idx = 4'(i);
        e.data = ld ? mem_m[a[9:2]] : regs[i];
        e.last = (k == n - 1);
        exp_q.push_back(e);
        a = a + 4; k++;
      end
    end
    base_q.push_back(wb ? fin : base);
    cmd_base = base; cmd_list = list; cmd_load = ld; cmd_mode = mode;
    cmd_wback = wb; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || base_q.size() != 0 || expect_done) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops expected items as the design produces accesses and results.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic acc;
      acc = mem_we || mem_re;
      if (want_acc) begin
        chk(acc, "R11", "access right after done", 32'(acc), 32'd1);
        want_acc = 0;
      end
      if (expect_done) begin
        chk(done, "R9", "done after last word", 32'(done), 32'd1);
        expect_done = 0;
      end
      if (acc) begin
        chk(!cmd_ready, "R1", "ready while busy", 32'(cmd_ready), 32'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected access", mem_addr, 32'hx);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          chk(mem_addr == e.addr, e.ld ? "R4/R3 load" : "R4/R3 store",
              "address", mem_addr, e.addr);
          chk(mem_re == e.ld && rf_we == e.ld, "R6", "direction",
              32'({mem_re, rf_we}), 32'({e.ld, e.ld}));
          if (e.ld) begin
            chk(rf_waddr == e.idx, "R2", "write index", 32'(rf_waddr), 32'(e.idx));
            chk(rf_wdata == e.data, "R6", "load data", rf_wdata, e.data);
          end else begin
            chk(rf_raddr == e.idx, "R2", "read index", 32'(rf_raddr), 32'(e.idx));
            chk(mem_wdata == e.data, "R5", "store data", mem_wdata, e.data);
          end
          if (e.last) expect_done = 1;
        end
      end
      if (done) begin
        if (base_q.size() == 0) begin
          chk(1'b0, "R9", "spurious done", 32'(done), 32'd0);
        end else begin
          logic [31:0] eb;
          eb = base_q.pop_front();
          chk(base_out == eb, "R7", "base_out", base_out, eb);
        end
        if (b2b_watch) begin
          chk(cmd_ready && cmd_valid, "R11", "ready in done cycle",
              32'({cmd_ready, cmd_valid}), 32'd3);
          b2b_watch = 0;
          want_acc = 1;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap [16];
    for (int i = 0; i < 256; i++) mem_m[i] = 32'hA000_0000 + 32'(i);
    for (int i = 0; i < 16; i++) regs[i] = 32'h5000_0000 + 32'(i * 17);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state (R1, R9)
    chk(cmd_ready == 1'b1, "R1", "ready after reset", 32'(cmd_ready), 32'd1);
    chk(!done && !mem_we && !mem_re && !rf_we, "R9", "quiet after reset",
        32'({done, mem_we, mem_re, rf_we}), 32'd0);

    issue(32'h40, 16'h000F, 1'b0, 2'd0, 1'b1);   // R3 R5 R7
    wait_idle();
    issue(32'h40, 16'h0A50, 1'b1, 2'd1, 1'b0);   // R3 R6 R7
    wait_idle();
    issue(32'h200, 16'h8001, 1'b0, 2'd2, 1'b1);  // R4
    wait_idle();
    issue(32'h200, 16'h0300, 1'b1, 2'd3, 1'b1);  // R4 R6
    wait_idle();
    issue(32'h123, 16'h0000, 1'b0, 2'd3, 1'b1);  // R8
    wait_idle();

    // R10: push then pop restores registers and base
    for (int i = 0; i < 16; i++) snap[i] = regs[i];
    issue(32'h300, 16'h40F2, 1'b0, 2'd3, 1'b1);
    wait_idle();
    for (int i = 0; i < 16; i++) if (16'h40F2 & (16'h1 << i)) regs[i] = 32'hDEAD_0000 + 32'(i);
    issue(32'h2E8, 16'h40F2, 1'b1, 2'd0, 1'b1);
    wait_idle();
    for (int i = 0; i < 16; i++)
      chk(regs[i] == snap[i], "R10", "restored register", regs[i], snap[i]);

    // R11 and R1: second command queued behind a running one
    b2b_watch = 1;
    issue(32'h380, 16'h0003, 1'b0, 2'd0, 1'b0);
    issue(32'h3A0, 16'h0030, 1'b1, 2'd0, 1'b0);
    wait_idle();

    chk(exp_q.size() == 0 && base_q.size() == 0, "R2", "all items seen",
        32'(exp_q.size() + base_q.size()), 32'd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule